// File: doc/BRIEF.md
# I/Q Word-to-Pin Bit Serializer

This block takes 32-bit words from the read side of a FIFO that holds I and Q samples in alternating order. Each word is sent out bit by bit, one bit per clock and least-significant bit first. Words that belong to I leave on one pin and words that belong to Q leave on a second pin. A third pin shows that the FIFO is full.

The block is the read-side consumer of that FIFO. It pulses the FIFO read enable once per word and captures the returned data one cycle later. It then shifts the word out over 32 clocks. When the last bit is on the pin and more data is waiting, it requests the next word. The FIFO full flag blanks both data pins and drops the word in progress. The I/Q channel order is kept across that event, so a word that was already started does not cause the pairing to slip.

Top module: `iq_bit_serializer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to idle on that edge, with the channel pointer on I. During reset and in the idle state after it, `fifo_rd_en`, `pin_i` and `pin_q` are all 0.
- R2: The first word read after reset is sent on `pin_i`. `pin_q` stays 0 during that word.
- R3: A word is shown only on the pin of its own channel. The pin of the other channel is 0. Neither pin is ever 1 in the same cycle as the other.
- R4: After a word has sent all 32 bits, the channel pointer switches, so completed words alternate I, Q, I, Q.
- R5: `fifo_rd_en` is 1 only when `fifo_empty` is 0 and `fifo_full` is 0. It is never 1 for two consecutive cycles.
- R6: While `fifo_full` is 1, `pin_ovf` is 1 and both `pin_i` and `pin_q` are 0. `pin_ovf` is 0 whenever `fifo_full` is 0.
- R7: Bits leave least-significant bit first. Bit k of a word is on the pin k cycles after bit 0.
- R8: Data is taken from `fifo_dout` on the cycle after `fifo_rd_en`. Bit 0 appears on the cycle after that capture. Each word holds its pin for 32 cycles. The next read is requested in the cycle of bit 31, so reads under continuous data are 33 cycles apart.
- R9: If `fifo_empty` is 1 when a word finishes, both data pins stay 0 until data arrives. The read is requested in the first cycle in which `fifo_empty` is 0.
- R10: If `fifo_full` rises while a word is being loaded or shifted, that word is dropped and the channel pointer does not change. The next word read goes to the same channel as the dropped one.
- R11: A reset in the middle of a word drops it. The first word after the reset goes to I, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_dout | input | 32 | FIFO read data, valid one cycle after the read enable |
| fifo_empty | input | 1 | FIFO has no words |
| fifo_full | input | 1 | FIFO is full |
| fifo_rd_en | output | 1 | One-cycle read request to the FIFO |
| pin_i | output | 1 | Serial output for I words |
| pin_q | output | 1 | Serial output for Q words |
| pin_ovf | output | 1 | High while the FIFO reports full |

## Verification
The test words are chosen so that each one tells apart a different error:
- A word with only bit 0 set, followed by a word with only bit 31 set, separates a right shift from a left shift. It also shows whether the first word lands on I and the second on Q.
- All-ones and all-zeros words expose a stuck pin or a wrong bit count.
- A continuous burst of six words measures the 33-cycle read spacing.
- An empty gap between words separates a block that holds its pins low from one that repeats stale bits.
- Raising full in the middle of a word, while the FIFO is idle, and resetting in the middle of a word each test one abandon path. Each run shows whether the channel order survives that event.

// File: rtl/iq_ser_pkg.sv
// Shared types for the I/Q bit serializer.
// Assumes: two channels only, I numbered 0 and Q numbered 1.
package iq_ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2
    } ser_state_e;

    typedef enum logic {
        CH_I = 1'b0,
        CH_Q = 1'b1
    } chan_e;

    localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/iq_rd_ctrl.sv
// Read controller: issues FIFO reads, tracks the bit position within a word
// and owns the I/Q channel pointer.
// Assumes: the FIFO returns data one cycle after the read enable, and
// WORD_W is a power of two.
module iq_rd_ctrl
    import iq_ser_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fifo_empty,
    input  logic  fifo_full,
    output logic  rd_en,
    output logic  load_stb,
    output logic  shift_stb,
    output chan_e active_ch
);

    localparam int unsigned CNT_W = $clog2(WORD_W);
    localparam int unsigned LAST  = WORD_W - 1;

    ser_state_e       state;
    logic [CNT_W-1:0] bit_cnt;
    logic             last_bit;

    // Decode the cycle in which the final bit of a word is on the pin.
    always_comb begin
        last_bit = (state == ST_SHIFT) && (bit_cnt == CNT_W'(LAST));
    end

    // Request a word when idle or on the last bit, only if data is present and the FIFO is not full.
    always_comb begin
        rd_en     = rst_n && !fifo_full && !fifo_empty &&
                    ((state == ST_IDLE) || last_bit);
        load_stb  = (state == ST_LOAD)  && !fifo_full;
        shift_stb = (state == ST_SHIFT) && !fifo_full;
    end

    // Sequence idle, load and shift; on full, drop the word and keep the channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            active_ch <= CH_I;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (rd_en) begin
                        state <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    bit_cnt <= '0;
                    state   <= fifo_full ? ST_IDLE : ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (fifo_full) begin
                        state <= ST_IDLE;
                    end else if (last_bit) begin
                        active_ch <= (active_ch == CH_I) ? CH_Q : CH_I;
                        bit_cnt   <= '0;
                        state     <= rd_en ? ST_LOAD : ST_IDLE;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // R1: reset leaves the controller idle on channel I.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (state == ST_IDLE) && (active_ch == CH_I));

    // R5: a read request never lasts more than one cycle.
    a_r5_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    // R8: a read is always followed by the capture state.
    a_r8_load_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (state == ST_LOAD));

    // R4: finishing a word flips the channel.
    a_r4_channel_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && !fifo_full) |=> (active_ch != $past(active_ch)));

    // R10: full during a word drops it and leaves the channel alone.
    a_r10_abandon_keeps_channel: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && fifo_full) |=> ($stable(active_ch) && (state == ST_IDLE)));

endmodule

// File: rtl/iq_shift_lane.sv
// One channel's shift register: captures a word on load and moves it right
// by one bit per shift strobe, presenting bit 0 as the serial bit.
// Assumes: load and shift are never asserted together by the controller.
module iq_shift_lane #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] din,
    output logic              bit_o
);

    logic [WORD_W-1:0] sreg;

    // Capture a fresh word or move the current one toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= din;
        end else if (shift) begin
            sreg <= {1'b0, sreg[WORD_W-1:1]};
        end
    end

    // Present the lowest bit as the serial output.
    always_comb begin
        bit_o = sreg[0];
    end

    // R7: each shift moves the word right by exactly one position.
    a_r7_shift_right: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (sreg == ($past(sreg) >> 1)));

endmodule

// File: rtl/iq_pin_drive.sv
// Output pin stage: routes the active lane's bit to its own pin, keeps the
// other pin low, and forces both data pins low while the FIFO is full.
// Assumes: shift_stb is high only while a word is on the pins.
module iq_pin_drive
    import iq_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_stb,
    input  chan_e             active_ch,
    input  logic [NUM_CH-1:0] lane_bits,
    input  logic              fifo_full,
    output logic              pin_i,
    output logic              pin_q,
    output logic              pin_ovf
);

    // Steer the active lane to its pin and blank everything on full.
    always_comb begin
        pin_i   = 1'b0;
        pin_q   = 1'b0;
        pin_ovf = fifo_full;
        if (shift_stb && !fifo_full) begin
            if (active_ch == CH_I) begin
                pin_i = lane_bits[0];
            end else begin
                pin_q = lane_bits[1];
            end
        end
    end

    // R3: the two data pins are never high together.
    a_r3_one_pin_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(pin_i && pin_q));

    // R6: full drives the overflow pin and silences both data pins.
    a_r6_full_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> (pin_ovf && !pin_i && !pin_q));

endmodule

// File: rtl/iq_bit_serializer.sv
// Top level: splits an interleaved I/Q FIFO stream into two serial pins,
// LSB first, with a full indicator pin.
// Assumes: FIFO read latency of one cycle; words strictly alternate I then Q.
module iq_bit_serializer
    import iq_ser_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] fifo_dout,
    input  logic              fifo_empty,
    input  logic              fifo_full,
    output logic              fifo_rd_en,
    output logic              pin_i,
    output logic              pin_q,
    output logic              pin_ovf
);

    logic              load_stb;
    logic              shift_stb;
    chan_e             active_ch;
    logic [NUM_CH-1:0] lane_bits;

    iq_rd_ctrl #(
        .WORD_W (WORD_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_full  (fifo_full),
        .rd_en      (fifo_rd_en),
        .load_stb   (load_stb),
        .shift_stb  (shift_stb),
        .active_ch  (active_ch)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        iq_shift_lane #(
            .WORD_W (WORD_W)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load_stb  && (active_ch == chan_e'(g))),
            .shift (shift_stb && (active_ch == chan_e'(g))),
            .din   (fifo_dout),
            .bit_o (lane_bits[g])
        );
    end

    iq_pin_drive u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_stb (shift_stb),
        .active_ch (active_ch),
        .lane_bits (lane_bits),
        .fifo_full (fifo_full),
        .pin_i     (pin_i),
        .pin_q     (pin_q),
        .pin_ovf   (pin_ovf)
    );

    // R5: reads are only issued against a FIFO with data and room.
    a_r5_read_legal: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en |-> (!fifo_empty && !fifo_full));

endmodule

// File: tb/iq_bit_serializer_tb.sv
// Self-checking bench: FIFO modelled by a queue, behavioural reference
// compared with the ports on every clock.
module iq_bit_serializer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fifo_dout = '0;
    logic        fifo_empty;
    logic        fifo_full = 1'b0;
    logic        fifo_rd_en;
    logic        pin_i;
    logic        pin_q;
    logic        pin_ovf;

    always #4 clk = ~clk;

    iq_bit_serializer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_dout  (fifo_dout),
        .fifo_empty (fifo_empty),
        .fifo_full  (fifo_full),
        .fifo_rd_en (fifo_rd_en),
        .pin_i      (pin_i),
        .pin_q      (pin_q),
        .pin_ovf    (pin_ovf)
    );

    logic [31:0] fifo_q[$];
    assign fifo_empty = (fifo_q.size() == 0);

    int    total = 0;
    int    bad   = 0;
    int    cyc   = 0;
    string ctx   = "R1";

    // reference model state: 0 idle, 1 load, 2 shift
    int          m_st  = 0;
    int          m_pos = 0;
    int          m_ch  = 0;
    logic [31:0] m_word = '0;

    // sampled values used at the next rising edge
    logic        s_rd = 1'b0;
    logic        s_rst = 1'b0;
    logic        s_full = 1'b0;
    logic [31:0] s_dout = '0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Per-cycle comparison against the reference model, between edges.
    always @(negedge clk) begin
        logic e_rd, e_i, e_q;
        #1;
        e_rd = rst_n && !fifo_full && !fifo_empty &&
               (m_st == 0 || (m_st == 2 && m_pos == 31));
        e_i = (m_st == 2) && !fifo_full && (m_ch == 0) && m_word[m_pos];
        e_q = (m_st == 2) && !fifo_full && (m_ch == 1) && m_word[m_pos];
        chk({ctx, "/R5 rd_en"}, 32'(fifo_rd_en), 32'(e_rd));
        chk({ctx, "/R3 pin_i"}, 32'(pin_i), 32'(e_i));
        chk({ctx, "/R3 pin_q"}, 32'(pin_q), 32'(e_q));
        chk({ctx, "/R6 pin_ovf"}, 32'(pin_ovf), 32'(fifo_full));
        s_rd   = fifo_rd_en;
        s_rst  = rst_n;
        s_full = fifo_full;
        s_dout = fifo_dout;
    end

    // FIFO model and reference model advance on the rising edge.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cyc);
            finish_run();
        end
        if (s_rd && fifo_q.size() > 0) fifo_dout <= fifo_q.pop_front();
        if (!s_rst) begin
            m_st = 0; m_pos = 0; m_ch = 0;
        end else begin
            case (m_st)
                0: if (s_rd) m_st = 1;
                1: begin
                    if (s_full) m_st = 0;
                    else begin m_word = s_dout; m_pos = 0; m_st = 2; end
                end
                default: begin
                    if (s_full) m_st = 0;
                    else if (m_pos == 31) begin
                        m_ch = 1 - m_ch; m_pos = 0;
                        m_st = s_rd ? 1 : 0;
                    end else m_pos++;
                end
            endcase
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_rd();
        int guard = 0;
        forever begin
            @(negedge clk); #2;
            if (fifo_rd_en) break;
            guard++;
            if (guard > 500) break;
        end
    endtask

    initial begin
        // R1: reset state
        ctx = "R1";
        tick(3); #2;
        chk("R1 rd_en in reset", 32'(fifo_rd_en), 0);
        chk("R1 pins in reset", {30'd0, pin_i, pin_q}, 0);
        @(negedge clk); rst_n = 1'b1;
        tick(2); #2;
        chk("R1 idle after reset", {29'd0, fifo_rd_en, pin_i, pin_q}, 0);

        // R2/R7/R4: bit-0 word on I then bit-31 word on Q
        ctx = "R2";
        @(negedge clk);
        fifo_q.push_back(32'h0000_0001);
        fifo_q.push_back(32'h8000_0000);
        tick(2); #2;
        chk("R2 first word on pin_i", 32'(pin_i), 1);
        chk("R7 bit0 first, pin_q idle", 32'(pin_q), 0);
        tick(1); #2;
        chk("R7 bit1 follows bit0", 32'(pin_i), 0);
        ctx = "R4";
        tick(63); #2;
        chk("R4 bit31 of second word on pin_q", {30'd0, pin_i, pin_q}, 1);
        tick(3);

        // R8: continuous stream read spacing
        ctx = "R8";
        @(negedge clk);
        fifo_q.push_back(32'hFFFF_FFFF);
        fifo_q.push_back(32'h0000_0000);
        fifo_q.push_back(32'hA5A5_0F0F);
        fifo_q.push_back(32'h1234_5678);
        fifo_q.push_back(32'hDEAD_BEEF);
        fifo_q.push_back(32'h0F0F_F0F0);
        wait_rd();
        begin
            int gap = 0;
            do begin
                @(negedge clk); #2; gap++;
            end while (!fifo_rd_en && gap < 100);
            chk("R8 read spacing", gap, 33);
        end
        tick(200);

        // R9: empty between words keeps pins low
        ctx = "R9";
        tick(2); #2;
        chk("R9 pins low while empty", {30'd0, pin_i, pin_q}, 0);
        @(negedge clk);
        fifo_q.push_back(32'h0000_0003);
        #2;
        chk("R9 read on first non-empty cycle", 32'(fifo_rd_en), 1);
        tick(40);

        // R10: full mid-word abandons, channel kept
        ctx = "R10";
        @(negedge clk);
        fifo_q.push_back(32'h0000_0001);
        fifo_q.push_back(32'h0000_0001);
        tick(10);
        fifo_full = 1'b1;
        #2;
        chk("R6 overflow pin high", 32'(pin_ovf), 1);
        chk("R6 data pins blanked", {30'd0, pin_i, pin_q}, 0);
        chk("R6 no read while full", 32'(fifo_rd_en), 0);
        tick(3);
        @(negedge clk); fifo_full = 1'b0;
        tick(100);

        // R6: full while idle with data waiting
        ctx = "R6";
        @(negedge clk);
        fifo_full = 1'b1;
        fifo_q.push_back(32'h5555_AAAA);
        tick(4); #2;
        chk("R6 no read while full and idle", 32'(fifo_rd_en), 0);
        @(negedge clk); fifo_full = 1'b0;
        tick(80);

        // R11: reset mid-word, next word on I
        ctx = "R11";
        @(negedge clk);
        fifo_q.push_back(32'hFFFF_FFFF);
        fifo_q.push_back(32'hFFFF_FFFF);
        tick(45);
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        fifo_q.delete();
        tick(3);
        fifo_q.push_back(32'h0000_0001);
        tick(2); #2;
        chk("R11 first word after reset on pin_i", {30'd0, pin_i, pin_q}, 2);
        tick(40);

        finish_run();
    end

endmodule